// File: doc/BRIEF.md
# Stack-Snooping Two-Bank Cartridge Switcher

This block sits on the cartridge side of a small 8-bit system bus. The bus has a 13-bit address, an 8-bit data bus and a read/write strobe. It picks one of two 4 KB ROM banks without any dedicated control register. It has no CPU clock. Instead it runs on a fast local clock and treats every accepted change of the address bus as the start of a new bus cycle. The address is synchronized and must stay at its new value for `STABLE_CLKS` local clocks before the change is accepted.

The switch is armed whenever the stack location 0x1FE is accessed, by a read or by a write. The byte on the data bus in the bus cycle after that access is captured `CAP_DELAY` local clocks into the cycle. Its bit 5 names the bank, and the new bank appears only when the next bus cycle starts. A subroutine call pushes its low return byte to 0x1FE and then fetches the high target byte. A return pulls from 0x1FE and then pulls the high byte. In both cases the byte that follows the 0x1FE access selects the bank, and the fetch in that following cycle still comes from the old bank. The bank drives the top bit of the ROM address. The cartridge window is decoded from address bit 12.

Top module: `stack_bank_switcher`

## Requirements
- R1: After reset the selected bank is 0 and no switch is armed or pending, so bus cycles that do not touch 0x1FE leave `rom_addr[12]` at 0.
- R2: `win_active` equals `bus_addr[12]`. `rom_oe` is `win_active` AND `bus_rw`, where `bus_rw` is 1 for a read. `rom_addr[11:0]` equals `bus_addr[11:0]`, and `rom_addr[12]` is the selected bank.
- R3: A write cycle to address 0x1FE arms the switch. The following bus cycle's data bit 5 then selects the bank: 1 selects bank 0 and 0 selects bank 1.
- R4: A read cycle at address 0x1FE arms the switch in the same way as a write.
- R5: The data byte present during the 0x1FE access itself has no effect on the bank. Only the byte of the cycle after it counts.
- R6: The new bank is not visible during the cycle that follows the trigger. It is visible from the start of the next bus cycle onward.
- R7: An address excursion that lasts fewer than `STABLE_CLKS` local clocks before returning to the previous address is not a bus cycle. This holds even when the excursion is to 0x1FE, so it arms nothing.
- R8: The switch works with arbitrarily long bus cycles, because cycle boundaries come only from address changes.
- R9: Accesses to any address other than exactly 0x1FE (for example 0x0FE, 0x1FF and 0x11FE) never arm the switch.
- R10: The data bus is sampled `CAP_DELAY` local clocks after the accepted address change. A data change later in the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, much faster than the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 13 | System address bus |
| bus_data | input | 8 | System data bus (sampled only) |
| bus_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| win_active | output | 1 | Cartridge window decode (address bit 12) |
| rom_oe | output | 1 | ROM output enable: window read |
| rom_addr | output | 13 | ROM address: bank bit above the 12-bit offset |

## Verification
The assertions assume the following about the bus:
- Each real bus cycle holds its address long enough for the synchronizer, the stability filter and the capture delay (at least 16 local clocks at the defaults).
- The data byte is valid from the address change until the capture point.
- Two consecutive real cycles never carry the same address.

The stimulus keeps to these rules. Every generated cycle lasts 16 or more clocks and is forced to differ in address from its predecessor. Data is driven together with the address, except in the directed late-change case. The only sub-threshold address pulses are deliberate one-clock excursions that return to the previous address.

// File: rtl/stack_bank_pkg.sv
package stack_bank_pkg;
  localparam int BUS_AW     = 13;
  localparam int BUS_DW     = 8;
  localparam int OFFSET_W   = 12;
  localparam logic [BUS_AW-1:0] STACK_TRIG = 13'h01FE;
  localparam int BANK_SEL_BIT = 5;

  typedef enum logic {BANK_LO = 1'b0, BANK_HI = 1'b1} bank_t;
endpackage

// File: rtl/bus_cycle_detect.sv
module bus_cycle_detect #(
  parameter int AW          = 13,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_sync,
  output logic [AW-1:0] cyc_addr,
  output logic          cyc_start
);
  localparam int CW = $clog2(STABLE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CLKS - 1);

  logic [AW-1:0] stg [SYNC_STAGES];
  logic [AW-1:0] cand_q;
  logic [CW-1:0] stab_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stg[i] <= '0;
        else if (i == 0) stg[i] <= addr_in;
        else             stg[i] <= stg[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign addr_sync = stg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q    <= '0;
      stab_q    <= '0;
      cyc_addr  <= '0;
      cyc_start <= 1'b0;
    end else begin
      cyc_start <= 1'b0;
      if (addr_sync != cand_q) begin
        cand_q <= addr_sync;
        stab_q <= '0;
      end else if (stab_q != LAST) begin
        stab_q <= stab_q + 1'b1;
      end else if (cand_q != cyc_addr) begin
        cyc_addr  <= cand_q;
        cyc_start <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cycle_data_capture.sv
module cycle_data_capture #(
  parameter int DW          = 8,
  parameter int AW          = 13,
  parameter int SYNC_STAGES = 2,
  parameter int CAP_DELAY   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data_in,
  input  logic          cyc_start,
  input  logic [AW-1:0] cyc_addr,
  output logic          cap_pulse,
  output logic [DW-1:0] cap_data,
  output logic [AW-1:0] cap_addr
);
  localparam int DCW = $clog2(CAP_DELAY + 1);

  logic [DW-1:0]  dstg [SYNC_STAGES];
  logic [DCW-1:0] dly_q;
  logic           busy_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_dsync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dstg[i] <= '0;
        else if (i == 0) dstg[i] <= data_in;
        else             dstg[i] <= dstg[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q     <= '0;
      busy_q    <= 1'b0;
      cap_pulse <= 1'b0;
      cap_data  <= '0;
      cap_addr  <= '0;
    end else begin
      cap_pulse <= 1'b0;
      if (cyc_start) begin
        dly_q  <= DCW'(CAP_DELAY);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (dly_q == DCW'(1)) begin
          busy_q    <= 1'b0;
          cap_pulse <= 1'b1;
          cap_data  <= dstg[SYNC_STAGES-1];
          cap_addr  <= cyc_addr;
        end
        dly_q <= dly_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_select_ctrl.sv
module bank_select_ctrl
  import stack_bank_pkg::*;
#(
  parameter int          AW      = 13,
  parameter int          DW      = 8,
  parameter logic [AW-1:0] TRIG  = 13'h01FE,
  parameter int          SEL_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start,
  input  logic          cap_pulse,
  input  logic [DW-1:0] cap_data,
  input  logic [AW-1:0] cap_addr,
  output bank_t         bank_q,
  output logic          armed_q,
  output logic          pend_q
);
  bank_t pend_bank_q;
  logic  unused_data_bits;

  assign unused_data_bits = ^cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q      <= BANK_LO;
      armed_q     <= 1'b0;
      pend_q      <= 1'b0;
      pend_bank_q <= BANK_LO;
    end else begin
      if (cyc_start && pend_q) begin
        bank_q <= pend_bank_q;
        pend_q <= 1'b0;
      end
      if (cap_pulse) begin
        armed_q <= (cap_addr == TRIG);
        if (armed_q) begin
          pend_q      <= 1'b1;
          pend_bank_q <= cap_data[SEL_BIT] ? BANK_LO : BANK_HI;
        end
      end
    end
  end
endmodule

// File: rtl/stack_bank_switcher.sv
module stack_bank_switcher
  import stack_bank_pkg::*;
#(
  parameter int ADDR_W      = BUS_AW,
  parameter int DATA_W      = BUS_DW,
  parameter int OFF_W       = OFFSET_W,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CLKS = 2,
  parameter int CAP_DELAY   = 4,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = STACK_TRIG,
  parameter int SEL_BIT     = BANK_SEL_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rw,
  output logic              win_active,
  output logic              rom_oe,
  output logic [OFF_W:0]    rom_addr
);
  logic [ADDR_W-1:0] addr_sync, cyc_addr, cap_addr;
  logic              cyc_start, cap_pulse;
  logic [DATA_W-1:0] cap_data;
  bank_t             bank_q;
  logic              armed_q, pend_q;

  bus_cycle_detect #(
    .AW(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .STABLE_CLKS(STABLE_CLKS)
  ) u_detect (
    .clk(clk), .rst_n(rst_n), .addr_in(bus_addr),
    .addr_sync(addr_sync), .cyc_addr(cyc_addr), .cyc_start(cyc_start)
  );

  cycle_data_capture #(
    .DW(DATA_W), .AW(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .CAP_DELAY(CAP_DELAY)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .data_in(bus_data),
    .cyc_start(cyc_start), .cyc_addr(cyc_addr),
    .cap_pulse(cap_pulse), .cap_data(cap_data), .cap_addr(cap_addr)
  );

  bank_select_ctrl #(
    .AW(ADDR_W), .DW(DATA_W), .TRIG(TRIG_ADDR), .SEL_BIT(SEL_BIT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .cap_pulse(cap_pulse), .cap_data(cap_data), .cap_addr(cap_addr),
    .bank_q(bank_q), .armed_q(armed_q), .pend_q(pend_q)
  );

  assign win_active = bus_addr[ADDR_W-1];
  assign rom_oe     = win_active & bus_rw;
  assign rom_addr   = {bank_q, bus_addr[OFF_W-1:0]};
endmodule

// File: rtl/stack_bank_checker.sv
module stack_bank_checker #(
  parameter int AW = 13,
  parameter logic [AW-1:0] TRIG = 13'h01FE
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bank_q,
  input logic          armed_q,
  input logic          pend_q,
  input logic          cyc_start,
  input logic          cap_pulse,
  input logic [AW-1:0] cap_addr,
  input logic [AW-1:0] cyc_addr,
  input logic [AW-1:0] addr_sync
);
  always @(posedge clk)
    if (!rst_n)
      assert_reset_state_R1: assert (bank_q == 1'b0 && armed_q == 1'b0 && pend_q == 1'b0);

  assert_arm_on_stack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_pulse && cap_addr == TRIG) |=> armed_q);

  assert_next_cycle_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(armed_q && cap_pulse));

  assert_bank_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> $past(cyc_start));

  assert_filtered_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (cyc_addr == $past(addr_sync)));

  assert_new_address_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (cyc_addr != $past(cyc_addr)));
endmodule

bind stack_bank_switcher stack_bank_checker #(.AW(ADDR_W), .TRIG(TRIG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_q(bank_q), .armed_q(armed_q), .pend_q(pend_q),
  .cyc_start(cyc_start), .cap_pulse(cap_pulse), .cap_addr(cap_addr),
  .cyc_addr(cyc_addr), .addr_sync(addr_sync)
);

// File: tb/sim_stack_bank_switcher.sv
module sim_stack_bank_switcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] bus_addr = 13'h0;
  logic [7:0]  bus_data = 8'h0;
  logic        bus_rw = 1'b1;
  logic        win_active, rom_oe;
  logic [12:0] rom_addr;

  int n_tests = 0;
  int n_fail  = 0;

  logic        m_bank = 1'b0;
  logic        m_armed = 1'b0;
  logic        m_pend = 1'b0;
  logic        m_pend_bank = 1'b0;
  logic [12:0] prev_addr = 13'h0;

  always #10 clk = ~clk;

  stack_bank_switcher u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rw(bus_rw), .win_active(win_active), .rom_oe(rom_oe), .rom_addr(rom_addr)
  );

  function automatic logic [12:0] exp_rom(input logic bank, input logic [12:0] a);
    return {bank, a[11:0]};
  endfunction

  function automatic logic bank_of(input logic [7:0] d);
    return d[5] ? 1'b0 : 1'b1;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_cycle(input logic [12:0] a, input logic [7:0] d, input logic rw,
                           input int len, input string req,
                           input int late_at, input logic [7:0] late_d);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_rw = rw;
    if (m_pend) begin m_bank = m_pend_bank; m_pend = 1'b0; end
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      if (i == late_at) bus_data = late_d;
    end
    check({req, " rom_addr"}, 32'(rom_addr), 32'(exp_rom(m_bank, a)));
    check("R2 win_active", 32'(win_active), 32'(a[12]));
    check("R2 rom_oe", 32'(rom_oe), 32'(a[12] & rw));
    if (m_armed) begin m_pend = 1'b1; m_pend_bank = bank_of(d); end
    m_armed = (a == 13'h01FE);
    prev_addr = a;
  endtask

  task automatic glitch_to_stack(input int settle);
    @(negedge clk);
    bus_addr = 13'h01FE;
    @(negedge clk);
    bus_addr = prev_addr;
    repeat (settle) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2600));
    repeat (5) @(negedge clk);
    check("R1 reset bank", 32'(rom_addr[12]), 32'd0);
    rst_n = 1'b1;

    bus_cycle(13'h1234, 8'hFF, 1'b1, 20, "R1", 0, 8'h0);
    bus_cycle(13'h0234, 8'h00, 1'b1, 20, "R2", 0, 8'h0);
    bus_cycle(13'h1555, 8'h00, 1'b0, 20, "R2", 0, 8'h0);
    bus_cycle(13'h1FFF, 8'h00, 1'b1, 20, "R1", 0, 8'h0);

    bus_cycle(13'h1100, 8'h20, 1'b1, 20, "R3", 0, 8'h0);
    bus_cycle(13'h01FF, 8'h11, 1'b0, 20, "R3", 0, 8'h0);
    bus_cycle(13'h01FE, 8'h02, 1'b0, 20, "R3", 0, 8'h0);
    bus_cycle(13'h1101, 8'h00, 1'b1, 20, "R6 old bank", 0, 8'h0);
    bus_cycle(13'h1200, 8'hA9, 1'b1, 20, "R3 bank1", 0, 8'h0);
    check("R3 switched to bank 1", 32'(rom_addr[12]), 32'd1);

    bus_cycle(13'h1300, 8'h60, 1'b1, 20, "R4", 0, 8'h0);
    bus_cycle(13'h01FE, 8'h00, 1'b1, 20, "R4", 0, 8'h0);
    bus_cycle(13'h01FF, 8'h3F, 1'b1, 20, "R6 old bank", 0, 8'h0);
    bus_cycle(13'h1010, 8'h00, 1'b1, 20, "R4 bank0", 0, 8'h0);
    check("R4 switched to bank 0", 32'(rom_addr[12]), 32'd0);

    bus_cycle(13'h01FE, 8'h00, 1'b0, 20, "R3", 0, 8'h0);
    bus_cycle(13'h1400, 8'h00, 1'b1, 20, "R3", 0, 8'h0);
    bus_cycle(13'h1401, 8'h00, 1'b1, 20, "R3 bank1", 0, 8'h0);
    bus_cycle(13'h01FE, 8'h00, 1'b0, 20, "R5", 0, 8'h0);
    bus_cycle(13'h1402, 8'h20, 1'b1, 20, "R5", 0, 8'h0);
    bus_cycle(13'h1403, 8'h00, 1'b1, 20, "R5", 0, 8'h0);
    check("R5 access byte ignored", 32'(rom_addr[12]), 32'd0);

    bus_cycle(13'h00FE, 8'h00, 1'b0, 20, "R9", 0, 8'h0);
    bus_cycle(13'h1500, 8'h00, 1'b1, 20, "R9", 0, 8'h0);
    bus_cycle(13'h01FF, 8'h00, 1'b0, 20, "R9", 0, 8'h0);
    bus_cycle(13'h1501, 8'h00, 1'b1, 20, "R9", 0, 8'h0);
    bus_cycle(13'h11FE, 8'h00, 1'b1, 20, "R9", 0, 8'h0);
    bus_cycle(13'h1502, 8'h00, 1'b1, 20, "R9", 0, 8'h0);
    bus_cycle(13'h1503, 8'h00, 1'b1, 20, "R9", 0, 8'h0);
    check("R9 no trigger elsewhere", 32'(rom_addr[12]), 32'd0);

    glitch_to_stack(14);
    bus_cycle(13'h1600, 8'h00, 1'b1, 20, "R7", 0, 8'h0);
    bus_cycle(13'h1601, 8'h00, 1'b1, 20, "R7", 0, 8'h0);
    check("R7 glitch ignored", 32'(rom_addr[12]), 32'd0);

    bus_cycle(13'h01FE, 8'h00, 1'b0, 300, "R8", 0, 8'h0);
    bus_cycle(13'h1700, 8'h00, 1'b1, 400, "R8", 0, 8'h0);
    bus_cycle(13'h1701, 8'h00, 1'b1, 250, "R8", 0, 8'h0);
    check("R8 long cycles bank1", 32'(rom_addr[12]), 32'd1);

    bus_cycle(13'h01FE, 8'h00, 1'b1, 20, "R10", 0, 8'h0);
    bus_cycle(13'h1800, 8'h20, 1'b1, 20, "R10", 14, 8'h00);
    bus_cycle(13'h1801, 8'h00, 1'b1, 20, "R10", 0, 8'h0);
    check("R10 late data ignored", 32'(rom_addr[12]), 32'd0);

    for (int k = 0; k < 700; k++) begin
      logic [12:0] a;
      a = ($urandom % 5 == 0) ? 13'h01FE : 13'($urandom);
      if (a == prev_addr) a = a ^ 13'h0001;
      if (k % 97 == 50) glitch_to_stack(14);
      bus_cycle(a, 8'($urandom), 1'($urandom), 16 + int'($urandom % 15), "R6", 0, 8'h0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule